// File: doc/BRIEF.md
# Logarithmic Programmable Barrel Shifter

This block is a purely combinational word shifter. It moves a 32-bit operand left or right by any distance from 0 to 31 positions in one evaluation. A direction input selects the way the bits move. A type input selects how the positions left empty are filled: with zeros, or with copies of the operand's top bit.

The shift is built from five cascaded mux layers. Each layer is steered by one bit of the shift amount, and it either passes its input through or moves it by a fixed power of two: 1, 2, 4, 8 or 16 positions. The layer distances add up, so any amount in the range is reached. The same cascade serves both directions. The fill value comes from the original operand's sign bit, not from any intermediate layer. Arithmetic fill takes effect only on right shifts. A left shift always brings in zeros.

Top module: `shf_core`

## Requirements
- R1: When the shift amount is 0, the output equals the input for every combination of direction and type.
- R2: With the direction input at 0 (left), output bit i equals input bit i−n for i ≥ n and is 0 for i < n, where n is the shift amount.
- R3: With the direction input at 1 (right) and the type input at 0 (logical), output bit i equals input bit i+n for i+n ≤ 31 and is 0 otherwise.
- R4: With the direction input at 1 (right) and the type input at 1 (arithmetic), every output bit whose source would lie above bit 31 takes the value of input bit 31.
- R5: The type input has no effect on a left shift. The output is the same whether it is 0 or 1.
- R6: Shift-amount bit k (k = 0..4) controls a layer that moves the data by 2^k positions. When that bit is 0, the layer passes its input through unchanged.
- R7: The layers combine, so every amount from 0 to 31 shifts by exactly that amount, including the maximum of 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 32 | Operand to be shifted |
| shamt_i | input | 5 | Shift distance, 0 to 31 |
| dir_right_i | input | 1 | 1 = shift toward bit 0, 0 = shift toward bit 31 |
| arith_i | input | 1 | 1 = sign fill on right shifts, 0 = zero fill |
| data_o | output | 32 | Shifted result |

## Verification
Several properties are checked whenever the inputs settle:
- an amount of zero leaves the data unchanged;
- each layer passes its input through when its control bit is clear;
- a left shift puts a zero in bit 0;
- a logical right shift puts a zero in bit 31 and never increases the number of set bits;
- an arithmetic right shift keeps the top bit.

Whether every bit lands in exactly the right place, how the five layer distances add up, and whether the type input is ignored on left shifts can only be confirmed by the bench. The bench compares full output words against its own bit-by-bit model, using random and corner-case operands.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic {
    SHF_TOWARD_MSB = 1'b0,
    SHF_TOWARD_LSB = 1'b1
  } shf_dir_e;

  typedef enum logic {
    SHF_ZERO_FILL = 1'b0,
    SHF_SIGN_FILL = 1'b1
  } shf_kind_e;

  // Value brought into vacated high positions; left shifts always take zero.
  function automatic logic pick_fill(input shf_dir_e dir,
                                     input shf_kind_e kind,
                                     input logic sign);
    if (dir == SHF_TOWARD_LSB && kind == SHF_SIGN_FILL) return sign;
    return 1'b0;
  endfunction

endpackage

// File: rtl/shf_fill_gen.sv
module shf_fill_gen
  import shf_pkg::*;
(
  input  logic dir_right_i,
  input  logic arith_i,
  input  logic sign_i,
  output logic fill_o
);
  shf_dir_e  dir;
  shf_kind_e kind;

  assign dir    = shf_dir_e'(dir_right_i);
  assign kind   = shf_kind_e'(arith_i);
  assign fill_o = pick_fill(dir, kind, sign_i);
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int WIDTH = 32,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] din_i,
  input  logic             en_i,
  input  logic             right_i,
  input  logic             fill_i,
  output logic [WIDTH-1:0] dout_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_hi;
    logic from_lo;
    if (i + DIST < WIDTH) begin : g_hi
      assign from_hi = din_i[i+DIST];
    end else begin : g_hi_fill
      assign from_hi = fill_i;
    end
    if (i >= DIST) begin : g_lo
      assign from_lo = din_i[i-DIST];
    end else begin : g_lo_zero
      assign from_lo = 1'b0;
    end
    assign dout_o[i] = en_i ? (right_i ? from_hi : from_lo) : din_i[i];
  end
endmodule

// File: rtl/shf_core.sv
module shf_core #(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] shamt_i,
  input  logic             dir_right_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] data_o
);
  localparam int STAGES = AMT_W;

  // Named internal points for the checker.
  logic                 fill_bit;
  logic [WIDTH-1:0]     stage_bus [STAGES+1];

  shf_fill_gen u_fill (
    .dir_right_i (dir_right_i),
    .arith_i     (arith_i),
    .sign_i      (data_i[WIDTH-1]),
    .fill_o      (fill_bit)
  );

  assign stage_bus[0] = data_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    shf_stage #(
      .WIDTH (WIDTH),
      .DIST  (1 << k)
    ) u_stage (
      .din_i   (stage_bus[k]),
      .en_i    (shamt_i[k]),
      .right_i (dir_right_i),
      .fill_i  (fill_bit),
      .dout_o  (stage_bus[k+1])
    );
  end

  assign data_o = stage_bus[STAGES];
endmodule

// File: rtl/shf_core_chk.sv
module shf_core_chk #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 5
) (
  input logic [WIDTH-1:0] data_i,
  input logic [AMT_W-1:0] shamt_i,
  input logic             dir_right_i,
  input logic             arith_i,
  input logic [WIDTH-1:0] data_o,
  input logic [WIDTH-1:0] stage_bus [AMT_W+1]
);
  always_comb begin
    if (shamt_i == '0)
      AST_ZERO_AMT_PASS: assert (data_o == data_i); // R1
    if (!dir_right_i && shamt_i != '0)
      AST_LEFT_LSB_ZERO: assert (data_o[0] == 1'b0); // R2
    if (dir_right_i && !arith_i && shamt_i != '0)
      AST_LOGIC_MSB_ZERO: assert (data_o[WIDTH-1] == 1'b0); // R3
    if (dir_right_i && !arith_i)
      AST_LOGIC_NO_NEW_ONES: assert ($countones(data_o) <= $countones(data_i)); // R3
    if (dir_right_i && arith_i)
      AST_ARITH_KEEPS_SIGN: assert (data_o[WIDTH-1] == data_i[WIDTH-1]); // R4
  end

  for (genvar k = 0; k < AMT_W; k++) begin : g_layer
    always_comb begin
      if (!shamt_i[k])
        AST_LAYER_IDLE_PASS: assert (stage_bus[k+1] == stage_bus[k]); // R6
    end
  end
endmodule

bind shf_core shf_core_chk #(
  .WIDTH (WIDTH),
  .AMT_W (AMT_W)
) u_chk (
  .data_i      (data_i),
  .shamt_i     (shamt_i),
  .dir_right_i (dir_right_i),
  .arith_i     (arith_i),
  .data_o      (data_o),
  .stage_bus   (stage_bus)
);

// File: tb/sim_shf_core.sv
`timescale 1ns/1ps
module sim_shf_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] data_i = '0;
  logic [4:0]  shamt_i = '0;
  logic        dir_right_i = 1'b0;
  logic        arith_i = 1'b0;
  logic [31:0] data_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  shf_core u0 (
    .data_i      (data_i),
    .shamt_i     (shamt_i),
    .dir_right_i (dir_right_i),
    .arith_i     (arith_i),
    .data_o      (data_o)
  );

  // Bit-by-bit reference built from the requirements.
  function automatic logic [31:0] model(input logic [31:0] d, input int n,
                                        input logic right, input logic ar);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (right) r[i] = (i + n <= 31) ? d[i+n] : (ar ? d[31] : 1'b0);
      else       r[i] = (i - n >= 0)  ? d[i-n] : 1'b0;
    end
    return r;
  endfunction

  task automatic run(input logic [31:0] d, input int n, input logic right,
                     input logic ar, input string req);
    logic [31:0] exp;
    @(posedge clk);
    data_i = d; shamt_i = 5'(n); dir_right_i = right; arith_i = ar;
    @(negedge clk);
    exp = model(d, n, right, ar);
    n_chk++;
    if (data_o !== exp) begin
      n_bad++;
      $display("FAIL %s: d=%h n=%0d right=%0b arith=%0b got %h exp %h",
               req, d, n, right, ar, data_o, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] got_a;
    logic [31:0] got_b;
    void'($urandom(32'd4242));
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;  // idle inputs give zero out
    if (data_o !== 32'h0) begin
      n_bad++;
      $display("FAIL R1: idle got %h exp %h", data_o, 32'h0);
    end
    // R1: zero amount in all four modes
    for (int m = 0; m < 4; m++) run(32'hA5C3_0F81, 0, m[1], m[0], "R1");
    // R2: left shifts, zero fill
    run(32'hFFFF_FFFF, 1, 1'b0, 1'b0, "R2");
    run(32'h8000_0001, 16, 1'b0, 1'b0, "R2");
    // R3: logical right
    run(32'h8000_0000, 1, 1'b1, 1'b0, "R3");
    run(32'hF0F0_F0F0, 13, 1'b1, 1'b0, "R3");
    // R4: arithmetic right, negative and positive operands
    run(32'h8000_0000, 31, 1'b1, 1'b1, "R4");
    run(32'h9234_5678, 7, 1'b1, 1'b1, "R4");
    run(32'h7FFF_FFFF, 30, 1'b1, 1'b1, "R4");
    // R5: type input ignored on a left shift
    run(32'hDEAD_BEEF, 9, 1'b0, 1'b1, "R5");
    @(posedge clk); data_i = 32'hC001_D00D; shamt_i = 5'd5;
    dir_right_i = 1'b0; arith_i = 1'b0;
    @(negedge clk); got_a = data_o;
    @(posedge clk); arith_i = 1'b1;
    @(negedge clk); got_b = data_o;
    n_chk++;
    if (got_b !== got_a) begin
      n_bad++;
      $display("FAIL R5: sign-fill left got %h exp %h", got_b, got_a);
    end
    // R6: each single layer alone
    for (int k = 0; k < 5; k++) begin
      run(32'h8421_1248, 1 << k, 1'b0, 1'b0, "R6");
      run(32'h8421_1248, 1 << k, 1'b1, 1'b1, "R6");
    end
    // R7: every amount, plus the maximum
    for (int n = 0; n < 32; n++) run(32'hB6D9_2493, n, n[0], n[1], "R7");
    run(32'h0000_0001, 31, 1'b0, 1'b0, "R7");
    run(32'h8000_0000, 31, 1'b1, 1'b0, "R7");
    // Random mix
    for (int j = 0; j < 400; j++)
      run($urandom, int'($urandom_range(0, 31)), 1'($urandom), 1'($urandom), "R7");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule